// File: doc/BRIEF.md
# Byte-Port Command/Response Mailbox

This block is the device-side host window of a security coprocessor. The host sees two byte-wide addresses, selected by `host_sel`. With `host_sel` low the host reaches the data port, where it writes command bytes and reads response bytes. With `host_sel` high a read returns a status byte and a write delivers a command code. Each command byte the host writes is placed in a one-byte input holding register. From there it goes to a local backend over a valid/ready byte stream.

After the host closes the command, the block builds a framed response in a one-byte output holding register. The frame starts with a flagged head marker. The backend's payload bytes follow, taken from a second valid/ready stream. A flagged tail marker ends the frame. A cancel code can be written at any time. It drops everything in flight, returns the handshake to idle and sends an abort pulse to the backend.

The controller has seven states. ST_IDLE is waiting for a start code. ST_RECV accepts command bytes. ST_CLOSE waits for the backend to take the close code. ST_HEAD holds the head marker. ST_BODY moves payload bytes into the output register. ST_DRAIN waits for the last payload byte to be read. ST_TAIL holds the tail marker. The transitions are:
- start: ST_IDLE to ST_RECV on code 0x01.
- close: ST_RECV to ST_CLOSE on code 0x03 while the input register is empty.
- handoff: ST_CLOSE to ST_HEAD once the backend has taken the close code.
- head-read: ST_HEAD to ST_BODY when the head marker has been read.
- last: ST_BODY to ST_DRAIN when a byte flagged last is loaded.
- drain: ST_DRAIN to ST_TAIL when that byte has been read.
- finish: ST_TAIL to ST_IDLE when the tail marker has been read.
- cancel: from any state to ST_IDLE on code 0x22.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, and whenever the block is idle, the status byte equals exactly 0x10.
- R2: Status bit positions are: bit0 output full, bit1 input full, bit2 frame flag, bit3 always 0, bit4 ready for command, bit5 ready for data, bits 7:6 always 0. Bit4 and bit5 are never set together.
- R3: Code 0x01 written at the command port while idle sets bit5 and clears bit4 (status 0x20).
- R4: A data-port write while bit5 is set and bit1 is clear loads the byte and sets bit1. The byte is offered on `cmd_data` with `cmd_valid` and held stable until `cmd_ready`. Bit1 clears on the edge where the backend takes it.
- R5: Code 0x03 written while receiving, with bit1 clear, is forwarded to the backend as byte 0x03 with `cmd_last` set. Bit5 clears. No earlier command byte carries `cmd_last`.
- R6: Once the backend has taken the close code, the data port presents 0x01 with bit0 and bit2 set (status 0x05). Bit2 is never set without bit0.
- R7: Each backend response byte is presented with bit0 set and bit2 clear. `rsp_ready` is only high while bit0 is clear. After the byte flagged `rsp_last` has been read, 0x03 is presented with bit0 and bit2 set. After that marker is read, the block is idle.
- R8: A data-port read while bit0 is set returns the held byte and clears bit0 on that edge.
- R9: Code 0x22 written in any state empties both holding registers, drops `cmd_valid`, leaves status exactly 0x10 on the next cycle, and raises `abort_pulse` for exactly one cycle.
- R10: A data-port write while bit5 is clear or bit1 is set is discarded and sets `proto_err`. Only reset clears `proto_err`.
- R11: Any other command code, and codes 0x01 or 0x03 written outside the state that accepts them, leave the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | 0 selects the data port, 1 selects the status/command port |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Status byte or held response byte, following `host_sel` |
| cmd_valid | output | 1 | Command byte available to backend |
| cmd_ready | input | 1 | Backend accepts command byte |
| cmd_data | output | 8 | Command byte |
| cmd_last | output | 1 | Marks the close code ending a command |
| rsp_valid | input | 1 | Backend response byte available |
| rsp_ready | output | 1 | Block takes response byte |
| rsp_data | input | 8 | Response byte |
| rsp_last | input | 1 | Marks the final payload byte |
| abort_pulse | output | 1 | One-cycle pulse following a cancel |
| proto_err | output | 1 | Sticky flag for discarded data writes |

## Verification
The hardest situations to reach are a cancel that lands while a byte is stuck in a holding register, and a cancel that lands in the middle of a response frame. In both cases the flush has to win over a pending load or a pending handoff. The bench holds `cmd_ready` low so that a command byte stays in the input register, then cancels. In a separate run it lets the head marker and the first payload byte reach the output register before cancelling. It then runs a new command to show that the response source restarts from its first byte.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
    localparam int BYTE_W = 8;

    // host command codes
    localparam logic [BYTE_W-1:0] CODE_START = 8'h01;
    localparam logic [BYTE_W-1:0] CODE_CLOSE = 8'h03;
    localparam logic [BYTE_W-1:0] CODE_ABORT = 8'h22;

    // frame markers presented on the data port
    localparam logic [BYTE_W-1:0] MARK_HEAD = 8'h01;
    localparam logic [BYTE_W-1:0] MARK_TAIL = 8'h03;

    // status bit positions
    localparam int SB_OBF = 0;
    localparam int SB_IBF = 1;
    localparam int SB_F0  = 2;
    localparam int SB_A2  = 3;
    localparam int SB_RDY = 4;
    localparam int SB_IBR = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_CLOSE,
        ST_HEAD,
        ST_BODY,
        ST_DRAIN,
        ST_TAIL
    } mbx_state_e;

    typedef enum logic [1:0] {
        OB_HEAD,
        OB_BODY,
        OB_TAIL
    } ob_src_e;
endpackage

// File: rtl/mbx_inbuf.sv
`timescale 1ns/1ps
module mbx_inbuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         load_last,
    output logic         full,
    input  logic         out_ready,
    output logic [W-1:0] out_data,
    output logic         out_last
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full     <= 1'b0;
            out_data <= '0;
            out_last <= 1'b0;
        end else if (flush) begin
            full     <= 1'b0;
            out_last <= 1'b0;
        end else if (load) begin
            full     <= 1'b1;
            out_data <= load_data;
            out_last <= load_last;
        end else if (full && out_ready) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/mbx_outbuf.sv
`timescale 1ns/1ps
module mbx_outbuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         load_flag,
    input  logic         take,
    output logic         full,
    output logic         flag,
    output logic [W-1:0] data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            flag <= 1'b0;
            data <= '0;
        end else if (flush) begin
            full <= 1'b0;
            flag <= 1'b0;
        end else if (load) begin
            full <= 1'b1;
            flag <= load_flag;
            data <= load_data;
        end else if (full && take) begin
            full <= 1'b0;
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/mbx_ctrl.sv
`timescale 1ns/1ps
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_wr,
    input  logic [W-1:0] cmd_code,
    input  logic         data_wr,
    input  logic         in_full,
    input  logic         out_full,
    input  logic         rsp_valid,
    input  logic         rsp_last,
    output logic         rdy,
    output logic         ibr,
    output logic         flush,
    output logic         in_load,
    output logic         in_eoc,
    output logic         out_load,
    output ob_src_e      out_src,
    output logic         rsp_ready,
    output logic         abort_pulse,
    output logic         proto_err
);
    mbx_state_e st, nxt;
    logic       cancel, start, close;

    assign cancel = cmd_wr && (cmd_code == CODE_ABORT);
    assign start  = cmd_wr && (cmd_code == CODE_START);
    assign close  = cmd_wr && (cmd_code == CODE_CLOSE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = st;
        if (cancel) begin
            nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:  if (start) nxt = ST_RECV;
                ST_RECV:  if (close && !in_full) nxt = ST_CLOSE;
                ST_CLOSE: if (!in_full) nxt = ST_HEAD;
                ST_HEAD:  if (!out_full) nxt = ST_BODY;
                ST_BODY:  if (rsp_valid && !out_full && rsp_last) nxt = ST_DRAIN;
                ST_DRAIN: if (!out_full) nxt = ST_TAIL;
                ST_TAIL:  if (!out_full) nxt = ST_IDLE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        rdy       = 1'b0;
        ibr       = 1'b0;
        flush     = cancel;
        in_load   = 1'b0;
        in_eoc    = cmd_wr;
        out_load  = 1'b0;
        out_src   = OB_BODY;
        rsp_ready = 1'b0;
        unique case (st)
            ST_IDLE: rdy = 1'b1;
            ST_RECV: begin
                ibr     = 1'b1;
                in_load = !cancel && !in_full && (data_wr || close);
            end
            ST_CLOSE: begin
                out_load = !cancel && !in_full;
                out_src  = OB_HEAD;
            end
            ST_HEAD: ;
            ST_BODY: begin
                rsp_ready = !cancel && !out_full;
                out_load  = !cancel && !out_full && rsp_valid;
                out_src   = OB_BODY;
            end
            ST_DRAIN: begin
                out_load = !cancel && !out_full;
                out_src  = OB_TAIL;
            end
            ST_TAIL: ;
            default: ;
        endcase
    end

    // abort pulse and sticky protocol error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_pulse <= 1'b0;
            proto_err   <= 1'b0;
        end else begin
            abort_pulse <= cancel;
            if (data_wr && (st != ST_RECV || in_full)) proto_err <= 1'b1;
        end
    end
endmodule

// File: rtl/cmd_mailbox.sv
`timescale 1ns/1ps
module cmd_mailbox
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [BYTE_W-1:0] cmd_data,
    output logic              cmd_last,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [BYTE_W-1:0] rsp_data,
    input  logic              rsp_last,
    output logic              abort_pulse,
    output logic              proto_err
);
    logic              cmd_wr, data_wr, data_rd;
    logic              rdy, ibr, flush;
    logic              in_load, in_eoc, in_full;
    logic              out_load, out_full, out_flag;
    logic [BYTE_W-1:0] out_data, ob_byte, ib_byte;
    logic              ob_flag;
    ob_src_e           out_src;
    logic [7:0]        status_byte;

    assign cmd_wr  = host_wr && host_sel;
    assign data_wr = host_wr && !host_sel;
    assign data_rd = host_rd && !host_sel;

    mbx_ctrl #(.W(BYTE_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .cmd_code    (host_wdata),
        .data_wr     (data_wr),
        .in_full     (in_full),
        .out_full    (out_full),
        .rsp_valid   (rsp_valid),
        .rsp_last    (rsp_last),
        .rdy         (rdy),
        .ibr         (ibr),
        .flush       (flush),
        .in_load     (in_load),
        .in_eoc      (in_eoc),
        .out_load    (out_load),
        .out_src     (out_src),
        .rsp_ready   (rsp_ready),
        .abort_pulse (abort_pulse),
        .proto_err   (proto_err)
    );

    assign ib_byte = in_eoc ? CODE_CLOSE : host_wdata;

    mbx_inbuf #(.W(BYTE_W)) u_inbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .load      (in_load),
        .load_data (ib_byte),
        .load_last (in_eoc),
        .full      (in_full),
        .out_ready (cmd_ready),
        .out_data  (cmd_data),
        .out_last  (cmd_last)
    );
    assign cmd_valid = in_full;

    always_comb begin
        unique case (out_src)
            OB_HEAD: begin ob_byte = MARK_HEAD; ob_flag = 1'b1; end
            OB_TAIL: begin ob_byte = MARK_TAIL; ob_flag = 1'b1; end
            default: begin ob_byte = rsp_data;  ob_flag = 1'b0; end
        endcase
    end

    mbx_outbuf #(.W(BYTE_W)) u_outbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .load      (out_load),
        .load_data (ob_byte),
        .load_flag (ob_flag),
        .take      (data_rd),
        .full      (out_full),
        .flag      (out_flag),
        .data      (out_data)
    );

    always_comb begin
        status_byte         = '0;
        status_byte[SB_OBF] = out_full;
        status_byte[SB_IBF] = in_full;
        status_byte[SB_F0]  = out_full && out_flag;
        status_byte[SB_A2]  = 1'b0;
        status_byte[SB_RDY] = rdy;
        status_byte[SB_IBR] = ibr;
    end

    assign host_rdata = host_sel ? status_byte : out_data;
endmodule

// File: rtl/mbx_checker.sv
`timescale 1ns/1ps
module mbx_checker
    import mbx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] status,
    input logic       host_sel,
    input logic       host_wr,
    input logic       host_rd,
    input logic [7:0] host_wdata,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [7:0] cmd_data,
    input logic       cmd_last,
    input logic       rsp_ready,
    input logic       abort_pulse,
    input logic       proto_err
);
    logic cancel_w;
    assign cancel_w = host_wr && host_sel && (host_wdata == CODE_ABORT);

    AST_IDLE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        status[SB_RDY] |-> (status == 8'h10)); // R1
    AST_RDY_IBR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({status[SB_RDY], status[SB_IBR]})); // R2
    AST_IBF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_sel && status[SB_IBR] && !status[SB_IBF] && !cancel_w) |=> status[SB_IBF]); // R4
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready && !cancel_w) |=> (cmd_valid && $stable(cmd_data))); // R4
    AST_LAST_IS_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_last) |-> (cmd_data == CODE_CLOSE)); // R5
    AST_F0_NEEDS_OBF: assert property (@(posedge clk) disable iff (!rst_n)
        status[SB_F0] |-> status[SB_OBF]); // R6
    AST_RSP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> !status[SB_OBF]); // R7
    AST_OBF_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_sel && status[SB_OBF]) |=> !status[SB_OBF]); // R8
    AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_w |=> (status == 8'h10 && abort_pulse && !cmd_valid)); // R9
    AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> $past(cancel_w)); // R9
    AST_BAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_sel && (!status[SB_IBR] || status[SB_IBF])) |=> proto_err); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err); // R10
endmodule

bind cmd_mailbox mbx_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .status      (status_byte),
    .host_sel    (host_sel),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_wdata  (host_wdata),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_data    (cmd_data),
    .cmd_last    (cmd_last),
    .rsp_ready   (rsp_ready),
    .abort_pulse (abort_pulse),
    .proto_err   (proto_err)
);

// File: tb/sim_cmd_mailbox.sv
`timescale 1ns/1ps
module sim_cmd_mailbox;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       h_sel = 1'b1, h_wr = 1'b0, h_rd = 1'b0;
    logic [7:0] h_wdata = 8'h00;
    logic [7:0] h_rdata;
    logic       cmd_valid, cmd_last, rsp_ready, abort, err;
    logic       cmd_ready = 1'b1;
    logic [7:0] cmd_data;
    logic       rsp_valid = 1'b0, rsp_last = 1'b0;
    logic [7:0] rsp_data = 8'h00;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    cmd_mailbox u0 (
        .clk(clk), .rst_n(rst_n),
        .host_sel(h_sel), .host_wr(h_wr), .host_rd(h_rd),
        .host_wdata(h_wdata), .host_rdata(h_rdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .cmd_last(cmd_last),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .rsp_last(rsp_last),
        .abort_pulse(abort), .proto_err(err)
    );

    // backend model: response source and command sink
    localparam int RLEN = 6;
    localparam logic [7:0] RSP_BYTES [RLEN] = '{8'h00, 8'hC4, 8'h00, 8'h00, 8'h00, 8'h06};
    int         ridx = 0;
    int         ncap = 0;
    logic [7:0] cap_d [16];
    logic       cap_l [16];

    initial begin
        forever begin
            @(negedge clk);
            rsp_valid = (ridx < RLEN);
            rsp_data  = (ridx < RLEN) ? RSP_BYTES[ridx] : 8'h00;
            rsp_last  = (ridx == RLEN - 1);
            #2;
            if (abort) ridx = 0;
            else if (rsp_valid && rsp_ready) ridx++;
            if (cmd_valid && cmd_ready && ncap < 16) begin
                cap_d[ncap] = cmd_data;
                cap_l[ncap] = cmd_last;
                ncap++;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // all host tasks start and end on a falling edge
    task automatic host_write(input logic s, input logic [7:0] d);
        h_sel = s; h_wr = 1'b1; h_wdata = d;
        @(negedge clk);
        h_wr = 1'b0;
    endtask

    task automatic host_read(input logic s, output logic [7:0] d);
        h_sel = s; h_rd = 1'b1;
        #1 d = h_rdata;
        @(negedge clk);
        h_rd = 1'b0;
    endtask

    task automatic poll(input logic [7:0] e, output bit ok);
        ok = 1'b0;
        h_sel = 1'b1;
        for (int k = 0; k < 64; k++) begin
            #1;
            if (h_rdata == e) ok = 1'b1;
            @(negedge clk);
            if (ok) break;
        end
    endtask

    task automatic expect_status(input string tag, input logic [7:0] e);
        h_sel = 1'b1;
        #1 check(tag, h_rdata, e);
        @(negedge clk);
    endtask

    // vector fields: {req[3:0], op[1:0], sel, data[7:0], expected[7:0]}
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_POLL = 2'd2;
    localparam int NV = 29;
    localparam logic [22:0] VEC [NV] = '{
        {4'd1, OP_RD,   1'b1, 8'h00, 8'h10},  // R1 idle status
        {4'd3, OP_WR,   1'b1, 8'h01, 8'h00},  // R3 start
        {4'd3, OP_RD,   1'b1, 8'h00, 8'h20},  // R3 ready for data
        {4'd4, OP_WR,   1'b0, 8'hAA, 8'h00},  // R4
        {4'd4, OP_RD,   1'b1, 8'h00, 8'h22},  // R4 input full
        {4'd4, OP_POLL, 1'b1, 8'h00, 8'h20},  // R4 drained
        {4'd4, OP_WR,   1'b0, 8'h55, 8'h00},
        {4'd4, OP_POLL, 1'b1, 8'h00, 8'h20},
        {4'd4, OP_WR,   1'b0, 8'h0F, 8'h00},
        {4'd4, OP_POLL, 1'b1, 8'h00, 8'h20},
        {4'd5, OP_WR,   1'b1, 8'h03, 8'h00},  // R5 close
        {4'd5, OP_RD,   1'b1, 8'h00, 8'h02},  // R5 ready-for-data gone
        {4'd6, OP_POLL, 1'b1, 8'h00, 8'h05},  // R6 head marker
        {4'd6, OP_RD,   1'b0, 8'h00, 8'h01},  // R6 R8
        {4'd7, OP_POLL, 1'b1, 8'h00, 8'h01},  // R7 payload
        {4'd7, OP_RD,   1'b0, 8'h00, 8'h00},
        {4'd7, OP_POLL, 1'b1, 8'h00, 8'h01},
        {4'd7, OP_RD,   1'b0, 8'h00, 8'hC4},
        {4'd7, OP_POLL, 1'b1, 8'h00, 8'h01},
        {4'd7, OP_RD,   1'b0, 8'h00, 8'h00},
        {4'd7, OP_POLL, 1'b1, 8'h00, 8'h01},
        {4'd7, OP_RD,   1'b0, 8'h00, 8'h00},
        {4'd7, OP_POLL, 1'b1, 8'h00, 8'h01},
        {4'd7, OP_RD,   1'b0, 8'h00, 8'h00},
        {4'd7, OP_POLL, 1'b1, 8'h00, 8'h01},
        {4'd7, OP_RD,   1'b0, 8'h00, 8'h06},
        {4'd7, OP_POLL, 1'b1, 8'h00, 8'h05},  // R7 tail marker
        {4'd7, OP_RD,   1'b0, 8'h00, 8'h03},
        {4'd1, OP_POLL, 1'b1, 8'h00, 8'h10}   // R1 idle again
    };

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        bit         ok;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        #1;
        check("R1 reset status", h_rdata, 8'h10);
        check("R1 reset cmd_valid", cmd_valid, 0);
        check("R9 reset abort", abort, 0);
        check("R10 reset err", err, 0);
        @(negedge clk);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            logic [22:0] v;
            string       tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec %0d", v[22:19], i);
            unique case (v[18:17])
                OP_WR: host_write(v[16], v[15:8]);
                OP_RD: begin host_read(v[16], rd); check(tag, rd, v[7:0]); end
                default: begin poll(v[7:0], ok); check(tag, ok, 1); end
            endcase
        end

        // R5 command stream content and last flag
        check("R5 count", ncap, 4);
        check("R5 bytes", {cap_d[0], cap_d[1], cap_d[2], cap_d[3]}, 32'hAA550F03);
        check("R5 last", {cap_l[0], cap_l[1], cap_l[2], cap_l[3]}, 4'b0001);

        // R11 misplaced and unknown codes
        host_write(1'b1, 8'h03);
        expect_status("R11 close in idle", 8'h10);
        host_write(1'b1, 8'h7E);
        expect_status("R11 unknown in idle", 8'h10);
        host_write(1'b1, 8'h01);
        host_write(1'b1, 8'h01);
        expect_status("R11 start in recv", 8'h20);
        host_write(1'b1, 8'h5A);
        expect_status("R11 unknown in recv", 8'h20);

        // R10 write while input full is discarded
        cmd_ready = 1'b0;
        host_write(1'b0, 8'hAA);
        expect_status("R4 held", 8'h22);
        host_write(1'b0, 8'hBB);
        #1;
        check("R10 err set", err, 1);
        check("R4 data stable", cmd_data, 8'hAA);
        @(negedge clk);
        cmd_ready = 1'b1;
        poll(8'h20, ok);
        check("R4 drained", ok, 1);
        repeat (3) @(negedge clk);
        check("R10 only first byte", ncap, 5);
        check("R10 kept byte", cap_d[4], 8'hAA);

        // R9 cancel with a stuck command byte
        cmd_ready = 1'b0;
        host_write(1'b0, 8'hCC);
        host_write(1'b1, 8'h22);
        #1;
        check("R9 abort pulse", abort, 1);
        check("R9 status idle", h_rdata, 8'h10);
        check("R9 cmd flushed", cmd_valid, 0);
        @(negedge clk);
        #1;
        check("R9 pulse one cycle", abort, 0);
        check("R10 err sticky", err, 1);
        @(negedge clk);
        cmd_ready = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 byte dropped", ncap, 5);

        // R9 cancel in the middle of a response
        host_write(1'b1, 8'h01);
        host_write(1'b0, 8'h11);
        poll(8'h20, ok);
        host_write(1'b1, 8'h03);
        poll(8'h05, ok);
        check("R6 head again", ok, 1);
        host_read(1'b0, rd);
        poll(8'h01, ok);
        check("R7 payload shown", ok, 1);
        host_write(1'b1, 8'h22);
        expect_status("R9 cancel mid response", 8'h10);

        // recovery: new frame restarts from the first payload byte
        host_write(1'b1, 8'h01);
        host_write(1'b1, 8'h03);
        poll(8'h05, ok);
        host_read(1'b0, rd);
        check("R6 head after cancel", rd, 8'h01);
        poll(8'h01, ok);
        host_read(1'b0, rd);
        check("R7 first byte after cancel", rd, 8'h00);
        poll(8'h01, ok);
        host_read(1'b0, rd);
        check("R8 second byte after cancel", rd, 8'hC4);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule